// File: doc/BRIEF.md
# Radio Packet Transmit Framer

This block turns bytes waiting in a transmit byte queue into one serial radio packet, one modulator bit per strobe. Each packet opens with a run of 0xAA preamble bytes and a programmable sync word. The payload bytes taken from the queue follow. An optional CCITT 16-bit checksum comes last. Payload and checksum bits can be sent as Manchester chip pairs. Preamble and sync bits are never coded.

The modulator owns the bit timing. It raises `bit_stb` for one clock each time it takes the bit shown on `mod_bit`. While `tx_en` is high, the framer sends preamble until the queue meets the configured start condition: either one byte is present, or the fill level has reached a threshold. After the last payload or checksum bit has been taken, the framer raises a one-clock `stop_pulse`. If `tx_en` is still high, it then begins a new preamble. Dropping `tx_en` returns the framer to idle at once.

Top module: `pkt_tx_framer`

## Requirements
- R1: While `tx_en` is low, `mod_bit` is 0, `fifo_pop` stays low and `stop_pulse` stays low, whatever `bit_stb` and the queue do.
- R2: Every packet begins with 2 + `cfg_pre_cnt` preamble bytes of value 0xAA. These are one automatic byte plus `cfg_pre_cnt`+1 programmed bytes. All bytes go MSB first, one bit per strobe, and are never Manchester coded.
- R3: The sync word follows the preamble. It is `cfg_sync_len`+1 bytes taken from `cfg_sync_word`, starting with bits 31:24 and moving down one byte at a time. It is sent uncoded.
- R4: With `cfg_start_first`=1, the sync word starts at the first byte boundary after the programmed preamble at which the queue is not empty. Until then, extra 0xAA bytes are sent.
- R5: With `cfg_start_first`=0, the sync word waits for a byte boundary at which `fifo_count` is at least `cfg_thresh`. Until then only 0xAA bytes go out and nothing is popped.
- R6: With `cfg_var_len`=0, exactly `cfg_fix_len` payload bytes (1..255) are popped and sent. Any further queue content is left in place. `fifo_pop` is raised only in a strobe cycle and only while the queue is not empty.
- R7: With `cfg_var_len`=1, the first payload byte is a length L, and L more bytes follow it. `cfg_fix_len` has no effect in this mode.
- R8: With `cfg_crc_en`=1, two checksum bytes follow the payload, high byte first. The checksum uses polynomial 0x1021 with initial value 0xFFFF and no final inversion. It covers every payload byte, including a length byte.
- R9: With `cfg_manch_en`=1, each payload and checksum bit is sent as two chips on consecutive strobes: 1 becomes 1,0 and 0 becomes 0,1.
- R10: `stop_pulse` is high for exactly one clock. That clock follows the edge at which the final chip of the packet was taken: the last checksum chip, or the last payload chip when the checksum is off.
- R11: If `tx_en` stays high after a packet, the next bits are a fresh uncoded 0xAA preamble.
- R12: One clock after `tx_en` is seen low, the framer is idle with `mod_bit`=0, and its checksum register is back at 0xFFFF. The next packet's checksum is therefore independent of an aborted one.
- R13: While the framer is active, `mod_bit` changes only at a clock edge where `bit_stb` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable level |
| fifo_data | input | 8 | Head byte of the queue (valid when not empty) |
| fifo_count | input | 7 | Bytes held in the queue |
| fifo_empty | input | 1 | Queue holds no byte |
| fifo_pop | output | 1 | Removes the head byte at this edge |
| cfg_pre_cnt | input | 2 | Programmed preamble bytes minus one |
| cfg_sync_len | input | 2 | Sync word bytes minus one |
| cfg_sync_word | input | 32 | Sync bytes, bits 31:24 sent first |
| cfg_var_len | input | 1 | First payload byte gives the length |
| cfg_fix_len | input | 8 | Payload length in fixed mode |
| cfg_crc_en | input | 1 | Append checksum |
| cfg_manch_en | input | 1 | Manchester-code payload and checksum |
| cfg_start_first | input | 1 | Start on first queued byte |
| cfg_thresh | input | 6 | Fill level that starts a packet when not starting on first byte |
| bit_stb | input | 1 | Modulator takes `mod_bit` at this edge |
| mod_bit | output | 1 | Current bit or chip for the modulator |
| stop_pulse | output | 1 | Final packet chip was taken |

## Verification
Three latencies matter. The first preamble bit shows on `mod_bit` one clock after `tx_en` is sampled high. Each strobed edge puts the next bit on `mod_bit` right after that edge, and `fifo_pop` is combinational in the strobe cycle at a byte boundary. `stop_pulse` appears in the clock after the final strobe, and a dropped `tx_en` forces idle after a single edge. The bench drives and samples only on falling edges. It records `mod_bit` in each cycle in which it raises the strobe, and it checks `stop_pulse` on the next falling edge. It compares the recorded bit stream segment by segment against a stream built from the requirements. Where preamble extension depends on when the queue is filled, the bench pushes bytes at known strobe positions, so the extra preamble count is exact.

// File: rtl/txf_pkg.sv
`timescale 1ns/1ps
package txf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_PAY,
        ST_CRC
    } txf_state_e;

    typedef struct packed {
        logic       load;
        logic [7:0] data;
        logic       coded;
    } txf_load_t;

    localparam logic [7:0]  PREAMBLE_BYTE = 8'hAA;
    localparam logic [15:0] CRC_POLY      = 16'h1021;
    localparam logic [15:0] CRC_INIT      = 16'hFFFF;
    localparam txf_load_t   LOAD_NONE     = '{load: 1'b0, data: 8'h00, coded: 1'b0};

    function automatic txf_load_t mk_load(input logic [7:0] d, input logic c);
        txf_load_t l;
        l.load  = 1'b1;
        l.data  = d;
        l.coded = c;
        return l;
    endfunction

    // Advance the checksum over one byte, MSB first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/txf_crc16.sv
`timescale 1ns/1ps
module txf_crc16
    import txf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || init) crc <= CRC_INIT;
        else if (upd)    crc <= crc16_byte(crc, din);
    end
endmodule

// File: rtl/txf_serializer.sv
`timescale 1ns/1ps
module txf_serializer
    import txf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  txf_load_t ld,
    input  logic      stb,
    output logic      mod_bit,
    output logic      last_chip
);
    logic [7:0] sh_q;
    logic [2:0] idx_q;
    logic       half_q;
    logic       coded_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q    <= '0;
            idx_q   <= '0;
            half_q  <= 1'b0;
            coded_q <= 1'b0;
        end else if (ld.load) begin
            sh_q    <= ld.data;
            idx_q   <= '0;
            half_q  <= 1'b0;
            coded_q <= ld.coded;
        end else if (stb) begin
            if (coded_q && !half_q) begin
                half_q <= 1'b1;
            end else begin
                half_q <= 1'b0;
                idx_q  <= idx_q + 3'd1;
                sh_q   <= {sh_q[6:0], 1'b0};
            end
        end
    end

    // Second chip of a coded bit is the inverse of the first.
    assign mod_bit   = sh_q[7] ^ (coded_q & half_q);
    assign last_chip = (idx_q == 3'd7) && (!coded_q || half_q);
endmodule

// File: rtl/pkt_tx_framer.sv
`timescale 1ns/1ps
module pkt_tx_framer
    import txf_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int SYNC_MAX   = 4,
    parameter int PRE_PROG_W = 2,
    parameter int LEN_W      = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
    localparam int THR_W     = $clog2(FIFO_DEPTH),
    localparam int SIDX_W    = $clog2(SYNC_MAX),
    localparam int SYNC_W    = 8 * SYNC_MAX,
    localparam int PRE_W     = PRE_PROG_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic [7:0]        fifo_data,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    input  logic [PRE_PROG_W-1:0] cfg_pre_cnt,
    input  logic [SIDX_W-1:0] cfg_sync_len,
    input  logic [SYNC_W-1:0] cfg_sync_word,
    input  logic              cfg_var_len,
    input  logic [LEN_W-1:0]  cfg_fix_len,
    input  logic              cfg_crc_en,
    input  logic              cfg_manch_en,
    input  logic              cfg_start_first,
    input  logic [THR_W-1:0]  cfg_thresh,
    input  logic              bit_stb,
    output logic              mod_bit,
    output logic              stop_pulse
);
    txf_state_e        state_q, nxt;
    logic [PRE_W-1:0]  pre_q, pre_d, pre_reload;
    logic [SIDX_W-1:0] sidx_q, sidx_d, sidx_inc;
    logic [LEN_W-1:0]  pay_q, pay_d, first_left;
    logic              lo_q, lo_d;
    logic              stop_q;
    logic              busy, bnd, last_chip, start_ok, fin, upd, crc_init;
    logic [15:0]       crc_q;
    txf_load_t         ld;
    logic [7:0]        sync_b [SYNC_MAX];

    for (genvar g = 0; g < SYNC_MAX; g++) begin : g_sync
        assign sync_b[g] = cfg_sync_word[SYNC_W-1-8*g -: 8];
    end

    assign busy       = (state_q != ST_IDLE);
    assign bnd        = tx_en && busy && bit_stb && last_chip;
    assign pre_reload = PRE_W'(cfg_pre_cnt) + PRE_W'(1);
    assign sidx_inc   = sidx_q + SIDX_W'(1);
    assign start_ok   = cfg_start_first ? !fifo_empty
                                        : (fifo_count >= CNT_W'(cfg_thresh));
    assign first_left = cfg_var_len ? LEN_W'(fifo_data)
                      : ((cfg_fix_len == '0) ? '0 : cfg_fix_len - LEN_W'(1));

    always_comb begin
        nxt      = state_q;
        ld       = LOAD_NONE;
        fifo_pop = 1'b0;
        upd      = 1'b0;
        fin      = 1'b0;
        pre_d    = pre_q;
        sidx_d   = sidx_q;
        pay_d    = pay_q;
        lo_d     = lo_q;
        if (!tx_en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    nxt   = ST_PRE;
                    ld    = mk_load(PREAMBLE_BYTE, 1'b0);
                    pre_d = pre_reload;
                end
                ST_PRE: if (bnd) begin
                    if (pre_q != '0) begin
                        ld    = mk_load(PREAMBLE_BYTE, 1'b0);
                        pre_d = pre_q - PRE_W'(1);
                    end else if (start_ok) begin
                        nxt    = ST_SYNC;
                        ld     = mk_load(sync_b[0], 1'b0);
                        sidx_d = '0;
                    end else begin
                        ld = mk_load(PREAMBLE_BYTE, 1'b0);
                    end
                end
                ST_SYNC: if (bnd) begin
                    if (sidx_q == cfg_sync_len) begin
                        nxt      = ST_PAY;
                        ld       = mk_load(fifo_data, cfg_manch_en);
                        fifo_pop = !fifo_empty;
                        upd      = 1'b1;
                        pay_d    = first_left;
                    end else begin
                        sidx_d = sidx_inc;
                        ld     = mk_load(sync_b[sidx_inc], 1'b0);
                    end
                end
                ST_PAY: if (bnd) begin
                    if (pay_q != '0) begin
                        ld       = mk_load(fifo_data, cfg_manch_en);
                        fifo_pop = !fifo_empty;
                        upd      = 1'b1;
                        pay_d    = pay_q - LEN_W'(1);
                    end else if (cfg_crc_en) begin
                        nxt  = ST_CRC;
                        ld   = mk_load(crc_q[15:8], cfg_manch_en);
                        lo_d = 1'b0;
                    end else begin
                        fin = 1'b1;
                    end
                end
                ST_CRC: if (bnd) begin
                    if (!lo_q) begin
                        ld   = mk_load(crc_q[7:0], cfg_manch_en);
                        lo_d = 1'b1;
                    end else begin
                        fin = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
            if (fin) begin
                nxt   = ST_PRE;
                ld    = mk_load(PREAMBLE_BYTE, 1'b0);
                pre_d = pre_reload;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pre_q   <= '0;
            sidx_q  <= '0;
            pay_q   <= '0;
            lo_q    <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            state_q <= nxt;
            pre_q   <= pre_d;
            sidx_q  <= sidx_d;
            pay_q   <= pay_d;
            lo_q    <= lo_d;
            stop_q  <= fin;
        end
    end

    assign crc_init   = !tx_en || fin || !busy;
    assign stop_pulse = stop_q;

    txf_crc16 u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (crc_init),
        .upd  (upd),
        .din  (fifo_data),
        .crc  (crc_q)
    );

    txf_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .clr       (!tx_en),
        .ld        (ld),
        .stb       (bit_stb && busy),
        .mod_bit   (mod_bit),
        .last_chip (last_chip)
    );
endmodule

// File: rtl/txf_checker.sv
`timescale 1ns/1ps
module txf_checker (
    input logic        clk,
    input logic        rst,
    input logic        tx_en,
    input logic        bit_stb,
    input logic        fifo_empty,
    input logic        fifo_pop,
    input logic        mod_bit,
    input logic        stop_pulse,
    input logic        busy,
    input logic [15:0] crc_q
);
    assert_idle_no_pop_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !fifo_pop);

    assert_pop_legal_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (!fifo_empty && bit_stb && tx_en));

    assert_stop_single_R10: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> !stop_pulse);

    assert_stop_after_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |-> $past(bit_stb));

    assert_drop_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (!busy && mod_bit == 1'b0));

    assert_drop_crc_clear_R12: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (crc_q == 16'hFFFF));

    assert_hold_without_strobe_R13: assert property (@(posedge clk) disable iff (rst)
        (busy && tx_en && !bit_stb) |=> $stable(mod_bit));
endmodule

bind pkt_tx_framer txf_checker u_txf_checker (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .bit_stb    (bit_stb),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .mod_bit    (mod_bit),
    .stop_pulse (stop_pulse),
    .busy       (busy),
    .crc_q      (crc_q)
);

// File: tb/test_pkt_tx_framer.sv
`timescale 1ns/1ps
module test_pkt_tx_framer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic [7:0]  fifo_data;
    logic [6:0]  fifo_count;
    logic        fifo_empty;
    logic        fifo_pop;
    logic [1:0]  cfg_pre_cnt = '0;
    logic [1:0]  cfg_sync_len = '0;
    logic [31:0] cfg_sync_word = '0;
    logic        cfg_var_len = 1'b0;
    logic [7:0]  cfg_fix_len = 8'd1;
    logic        cfg_crc_en = 1'b0;
    logic        cfg_manch_en = 1'b0;
    logic        cfg_start_first = 1'b1;
    logic [5:0]  cfg_thresh = '0;
    logic        bit_stb = 1'b0;
    logic        mod_bit;
    logic        stop_pulse;

    always #2.5 clk = ~clk;

    // Queue model
    logic [7:0] q [64];
    int wr = 0;
    int rd = 0;
    logic flush = 1'b0;
    always @(posedge clk) begin
        if (flush) rd <= wr;
        else if (fifo_pop && rd != wr) rd <= rd + 1;
    end
    assign fifo_data  = q[rd % 64];
    assign fifo_count = 7'(wr - rd);
    assign fifo_empty = (wr == rd);

    pkt_tx_framer i_pkt_tx_framer (
        .clk(clk), .rst(rst), .tx_en(tx_en),
        .fifo_data(fifo_data), .fifo_count(fifo_count), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop),
        .cfg_pre_cnt(cfg_pre_cnt), .cfg_sync_len(cfg_sync_len),
        .cfg_sync_word(cfg_sync_word), .cfg_var_len(cfg_var_len),
        .cfg_fix_len(cfg_fix_len), .cfg_crc_en(cfg_crc_en),
        .cfg_manch_en(cfg_manch_en), .cfg_start_first(cfg_start_first),
        .cfg_thresh(cfg_thresh), .bit_stb(bit_stb),
        .mod_bit(mod_bit), .stop_pulse(stop_pulse)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic rec [1024];
    logic expb [1024];
    int nrec, nexp, nstop, stop_at, npop_idle;
    logic [15:0] crc_acc;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [7:0] b);
        q[wr % 64] = b;
        wr++;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic crc_feed(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            if (crc_acc[15] ^ b[i]) crc_acc = {crc_acc[14:0], 1'b0} ^ 16'h1021;
            else                    crc_acc = {crc_acc[14:0], 1'b0};
        end
    endtask

    task automatic e_byte(input logic [7:0] b, input bit coded);
        for (int i = 7; i >= 0; i--) begin
            expb[nexp] = b[i]; nexp++;
            if (coded) begin expb[nexp] = ~b[i]; nexp++; end
        end
    endtask

    task automatic clear_rec();
        nrec = 0; nexp = 0; nstop = 0; stop_at = -1;
    endtask

    task automatic collect(input int upto);
        bit ph = 1'b1;
        while (nrec < upto) begin
            @(negedge clk);
            if (stop_pulse) begin nstop++; stop_at = nrec; end
            if (ph) begin rec[nrec] = mod_bit; nrec++; bit_stb = 1'b1; end
            else bit_stb = 1'b0;
            ph = !ph;
        end
        @(negedge clk);
        if (stop_pulse) begin nstop++; stop_at = nrec; end
        bit_stb = 1'b0;
    endtask

    task automatic seg(input string req, input string what, input int a, input int b);
        int bad = 0;
        int first = -1;
        for (int i = a; i < b; i++)
            if (rec[i] !== expb[i]) begin bad++; if (first < 0) first = i; end
        if (first < 0) first = a;
        check(bad == 0, req, what, longint'(rec[first]), longint'(expb[first]));
    endtask

    task automatic start_tx();
        @(negedge clk); tx_en = 1'b1; bit_stb = 1'b0;
    endtask

    task automatic stop_tx();
        @(negedge clk); tx_en = 1'b0; bit_stb = 1'b0;
    endtask

    task automatic t_reset_idle();
        push(8'h11);
        @(negedge clk);
        check(mod_bit == 1'b0 && stop_pulse == 1'b0, "R1", "reset outputs",
              {mod_bit, stop_pulse}, 0);
        npop_idle = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            bit_stb = i[0];
            if (fifo_pop || mod_bit || stop_pulse) npop_idle++;
        end
        bit_stb = 1'b0;
        check(npop_idle == 0 && fifo_count == 7'd1, "R1", "idle ignores strobes",
              npop_idle, 0);
        do_flush();
    endtask

    task automatic t_fixed();
        cfg_pre_cnt = 2'd1; cfg_sync_len = 2'd1; cfg_sync_word = 32'h2DD4_0000;
        cfg_var_len = 1'b0; cfg_fix_len = 8'd3; cfg_crc_en = 1'b0;
        cfg_manch_en = 1'b0; cfg_start_first = 1'b1;
        push(8'h5A); push(8'h01); push(8'hC3); push(8'h77);
        clear_rec();
        for (int i = 0; i < 3; i++) e_byte(8'hAA, 0);
        e_byte(8'h2D, 0); e_byte(8'hD4, 0);
        e_byte(8'h5A, 0); e_byte(8'h01, 0); e_byte(8'hC3, 0);
        e_byte(8'hAA, 0);
        start_tx();
        collect(72);
        seg("R2", "preamble 3 bytes", 0, 24);
        seg("R3", "sync 2 bytes", 24, 40);
        seg("R6", "fixed payload", 40, 64);
        check(nstop == 1 && stop_at == 64, "R10", "stop position", stop_at, 64);
        seg("R11", "preamble after packet", 64, 72);
        check(fifo_count == 7'd1, "R6", "bytes left in queue", fifo_count, 1);
        stop_tx();
        do_flush();
    endtask

    task automatic t_var_crc_manch();
        cfg_pre_cnt = 2'd0; cfg_sync_len = 2'd3; cfg_sync_word = 32'h1234_5678;
        cfg_var_len = 1'b1; cfg_fix_len = 8'd9; cfg_crc_en = 1'b1;
        cfg_manch_en = 1'b1; cfg_start_first = 1'b1;
        push(8'h03); push(8'h7E); push(8'h00); push(8'hFF); push(8'h99);
        crc_acc = 16'hFFFF;
        crc_feed(8'h03); crc_feed(8'h7E); crc_feed(8'h00); crc_feed(8'hFF);
        clear_rec();
        e_byte(8'hAA, 0); e_byte(8'hAA, 0);
        e_byte(8'h12, 0); e_byte(8'h34, 0); e_byte(8'h56, 0); e_byte(8'h78, 0);
        e_byte(8'h03, 1); e_byte(8'h7E, 1); e_byte(8'h00, 1); e_byte(8'hFF, 1);
        e_byte(crc_acc[15:8], 1); e_byte(crc_acc[7:0], 1);
        e_byte(8'hAA, 0);
        start_tx();
        collect(152);
        seg("R2", "two preamble bytes", 0, 16);
        seg("R3", "sync 4 bytes uncoded", 16, 48);
        seg("R9", "coded payload", 48, 112);
        seg("R8", "coded checksum", 112, 144);
        check(nstop == 1 && stop_at == 144, "R10", "stop after coded crc", stop_at, 144);
        check(fifo_count == 7'd1, "R7", "length byte overrides fixed", fifo_count, 1);
        seg("R11", "uncoded preamble after packet", 144, 152);
        stop_tx();
        do_flush();
    endtask

    task automatic t_wait_first();
        int ok_pre = 1;
        cfg_pre_cnt = 2'd0; cfg_sync_len = 2'd0; cfg_sync_word = 32'h9600_0000;
        cfg_var_len = 1'b0; cfg_fix_len = 8'd1; cfg_crc_en = 1'b0;
        cfg_manch_en = 1'b0; cfg_start_first = 1'b1;
        clear_rec();
        for (int i = 0; i < 7; i++) e_byte(8'hAA, 0);
        e_byte(8'h96, 0); e_byte(8'h3C, 0);
        start_tx();
        collect(48);
        for (int i = 0; i < 48; i++) if (rec[i] !== expb[i]) ok_pre = 0;
        check(ok_pre == 1 && nstop == 0, "R4", "preamble extends while empty", ok_pre, 1);
        push(8'h3C);
        collect(80);
        seg("R4", "extra preamble count", 48, 56);
        seg("R3", "sync after first byte", 56, 64);
        seg("R6", "single payload", 64, 72);
        check(nstop == 1 && stop_at == 72, "R10", "stop after waited packet", stop_at, 72);
        stop_tx();
        do_flush();
    endtask

    task automatic t_threshold();
        int ok_pre = 1;
        cfg_pre_cnt = 2'd0; cfg_sync_len = 2'd0; cfg_sync_word = 32'hE700_0000;
        cfg_var_len = 1'b0; cfg_fix_len = 8'd3; cfg_crc_en = 1'b0;
        cfg_manch_en = 1'b0; cfg_start_first = 1'b0; cfg_thresh = 6'd3;
        push(8'h81); push(8'h42);
        clear_rec();
        for (int i = 0; i < 6; i++) e_byte(8'hAA, 0);
        e_byte(8'hE7, 0); e_byte(8'h81, 0); e_byte(8'h42, 0); e_byte(8'h24, 0);
        start_tx();
        collect(40);
        for (int i = 0; i < 40; i++) if (rec[i] !== expb[i]) ok_pre = 0;
        check(ok_pre == 1, "R5", "only preamble below threshold", ok_pre, 1);
        check(fifo_count == 7'd2, "R5", "no pop below threshold", fifo_count, 2);
        push(8'h24);
        collect(96);
        seg("R5", "sync once threshold met", 40, 56);
        seg("R6", "payload after threshold", 56, 80);
        check(nstop == 1 && stop_at == 80, "R10", "stop after threshold packet", stop_at, 80);
        stop_tx();
        do_flush();
        cfg_start_first = 1'b1;
    endtask

    task automatic t_abort();
        cfg_pre_cnt = 2'd0; cfg_sync_len = 2'd0; cfg_sync_word = 32'h5A00_0000;
        cfg_var_len = 1'b0; cfg_fix_len = 8'd4; cfg_crc_en = 1'b1;
        cfg_manch_en = 1'b0; cfg_start_first = 1'b1;
        push(8'hF0); push(8'h0F); push(8'hA5); push(8'h3E);
        clear_rec();
        start_tx();
        collect(36);
        stop_tx();
        @(negedge clk);
        check(mod_bit == 1'b0 && nstop == 0, "R12", "idle after drop", mod_bit, 0);
        do_flush();
        push(8'h10); push(8'h20); push(8'h30); push(8'h40);
        crc_acc = 16'hFFFF;
        crc_feed(8'h10); crc_feed(8'h20); crc_feed(8'h30); crc_feed(8'h40);
        clear_rec();
        e_byte(8'hAA, 0); e_byte(8'hAA, 0); e_byte(8'h5A, 0);
        e_byte(8'h10, 0); e_byte(8'h20, 0); e_byte(8'h30, 0); e_byte(8'h40, 0);
        e_byte(crc_acc[15:8], 0); e_byte(crc_acc[7:0], 0);
        start_tx();
        collect(72);
        seg("R6", "payload after restart", 24, 56);
        seg("R12", "fresh checksum after abort", 56, 72);
        check(nstop == 1 && stop_at == 72, "R10", "stop after uncoded crc", stop_at, 72);
        stop_tx();
        do_flush();
    endtask

    task automatic t_hold();
        int changes = 0;
        logic prev;
        cfg_pre_cnt = 2'd0; cfg_start_first = 1'b1;
        start_tx();
        @(negedge clk);
        prev = mod_bit;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (mod_bit !== prev) changes++;
        end
        check(changes == 0 && mod_bit == 1'b1, "R13", "bit held without strobe", changes, 0);
        stop_tx();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_idle();
        t_fixed();
        t_var_crc_manch();
        t_wait_first();
        t_threshold();
        t_abort();
        t_hold();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule